// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block splits one instruction of a small 32-bit teaching instruction set into its fields. It takes the current program counter and a six-byte little-endian window of instruction memory that starts at that address. The first byte gives the operation code and the function code. The operation code alone decides two things: whether a register-specifier byte follows, and whether a four-byte constant follows. From those two facts the block derives the instruction length and the address of the next sequential instruction.

The decoded fields are registered, so the result appears one clock after an input is accepted. Any field the instruction does not carry is forced to zero, so later stages never pick up leftover window bytes. An operation code outside the defined set is flagged as invalid. In that case the block advances by a single byte.

Top module: `fd_decode`

## Requirements
- R1: While reset is asserted, and on the first rising edge after it, out_valid is 0 and every decoded output is 0.
- R2: out_valid equals in_valid one cycle later. The decoded outputs change only on a cycle where in_valid is 1; otherwise they keep their previous values.
- R3: icode is the upper nibble of window byte 0 and ifun is its lower nibble. Window byte k sits at window bits [8k+7:8k].
- R4: need_regids is 1 for operation codes 0x2 (register move), 0x3 (load immediate), 0x4 (register to memory), 0x5 (memory to register), 0x6 (ALU), 0xA (push) and 0xB (pop). When it is 1, ra is the upper nibble of byte 1 and rb is its lower nibble; a nibble of 8 is passed through unchanged as "no register".
- R5: need_valc is 1 for operation codes 0x3, 0x4, 0x5, 0x7 (jump) and 0x8 (call). valc is read little-endian from bytes 2..5 when need_regids is 1, and from bytes 1..4 when it is 0.
- R6: valp is pc+1 for codes 0x0 (nop), 0x1 (halt) and 0x9 (return); pc+2 for 0x2, 0x6, 0xA and 0xB; pc+5 for 0x7 and 0x8; and pc+6 for 0x3, 0x4 and 0x5.
- R7: When need_regids is 0, ra and rb are 0. When need_valc is 0, valc is 0.
- R8: For operation codes 0xC to 0xF, instr_valid is 0, need_regids and need_valc are 0, and valp is pc+1. icode and ifun still report byte 0. For codes 0x0 to 0xB, instr_valid is 1.
- R9: The valp addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A window and pc are presented this cycle |
| pc | input | 32 | Address of window byte 0 |
| window | input | 48 | Six instruction bytes, byte 0 in the low bits |
| out_valid | output | 1 | Decoded fields are for an input accepted last cycle |
| icode | output | 4 | Operation code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier |
| rb | output | 4 | Second register specifier |
| valc | output | 32 | Constant word |
| valp | output | 32 | Address of the next sequential instruction |
| need_regids | output | 1 | A register byte is present |
| need_valc | output | 1 | A constant word is present |
| instr_valid | output | 1 | The operation code is defined |

## Verification
Every defined operation code is decoded at least once, so each of the four length classes is covered. The window bytes that lie beyond each instruction's length are filled with nonzero junk, which shows whether the block wrongly reads them. Jump and call words are set beside load and memory-move words so that the two constant offsets can be told apart. Pairs with ifun nonzero separate the function nibble from the opcode nibble. Invalid codes, and addresses near 0xFFFFFFFF, expose the one-byte fallback and the wrap of valp. Directed steps then cover reset, idle cycles that must hold the outputs, and reset applied in the middle of a run.

// File: rtl/fd_pkg.sv
package fd_pkg;

    parameter int ADDR_W     = 32;
    parameter int NIB_W      = 4;
    parameter int BYTE_W     = 8;
    parameter int WORD_BYTES = 4;
    localparam int WORD_W    = WORD_BYTES * BYTE_W;
    localparam int WIN_BYTES = WORD_BYTES + 2;
    localparam int WIN_W     = WIN_BYTES * BYTE_W;
    localparam int LEN_W     = $clog2(WIN_BYTES + 1);

    typedef enum logic [NIB_W-1:0] {
        OP_NOP   = 4'h0,
        OP_HALT  = 4'h1,
        OP_RRMOV = 4'h2,
        OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4,
        OP_MRMOV = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    typedef struct packed {
        logic [NIB_W-1:0]  icode;
        logic [NIB_W-1:0]  ifun;
        logic [NIB_W-1:0]  ra;
        logic [NIB_W-1:0]  rb;
        logic [WORD_W-1:0] valc;
        logic [ADDR_W-1:0] valp;
        logic              need_regids;
        logic              need_valc;
        logic              instr_valid;
    } dec_t;

    typedef struct packed {
        logic vld;
        dec_t dec;
    } stage_t;

endpackage

// File: rtl/fd_class.sv
module fd_class
    import fd_pkg::*;
(
    input  logic [NIB_W-1:0] opcode,
    output logic             has_regs,
    output logic             has_word,
    output logic             known,
    output logic [LEN_W-1:0] len_bytes
);

    always_comb begin
        has_regs = 1'b0;
        has_word = 1'b0;
        known    = 1'b1;
        unique case (op_e'(opcode))
            OP_NOP, OP_HALT, OP_RET: begin
            end
            OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: begin
                has_regs = 1'b1;
            end
            OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
                has_regs = 1'b1;
                has_word = 1'b1;
            end
            OP_JUMP, OP_CALL: begin
                has_word = 1'b1;
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end

    // one opcode byte, plus a register byte, plus a constant word
    always_comb begin
        len_bytes = LEN_W'(1);
        if (has_regs) len_bytes = len_bytes + LEN_W'(1);
        if (has_word) len_bytes = len_bytes + LEN_W'(WORD_BYTES);
    end

endmodule

// File: rtl/fd_extract.sv
module fd_extract
    import fd_pkg::*;
(
    input  logic [WIN_W-BYTE_W-1:0] tail,
    input  logic                    has_regs,
    input  logic                    has_word,
    output logic [NIB_W-1:0]        ra,
    output logic [NIB_W-1:0]        rb,
    output logic [WORD_W-1:0]       valc
);

    logic [WORD_W-1:0] word_near;
    logic [WORD_W-1:0] word_far;

    // tail byte 0 is window byte 1
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
        assign word_near[k*BYTE_W +: BYTE_W] = tail[k*BYTE_W +: BYTE_W];
        assign word_far[k*BYTE_W +: BYTE_W]  = tail[(k+1)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        ra   = '0;
        rb   = '0;
        valc = '0;
        if (has_regs) begin
            ra = tail[BYTE_W-1 -: NIB_W];
            rb = tail[NIB_W-1:0];
        end
        if (has_word) begin
            valc = has_regs ? word_far : word_near;
        end
    end

endmodule

// File: rtl/fd_decode.sv
module fd_decode
    import fd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WIN_W-1:0]  window,
    output logic              out_valid,
    output logic [NIB_W-1:0]  icode,
    output logic [NIB_W-1:0]  ifun,
    output logic [NIB_W-1:0]  ra,
    output logic [NIB_W-1:0]  rb,
    output logic [WORD_W-1:0] valc,
    output logic [ADDR_W-1:0] valp,
    output logic              need_regids,
    output logic              need_valc,
    output logic              instr_valid
);

    logic [NIB_W-1:0]  op_nib;
    logic [NIB_W-1:0]  fn_nib;
    logic              has_regs;
    logic              has_word;
    logic              known;
    logic [LEN_W-1:0]  len_bytes;
    logic [NIB_W-1:0]  ra_w;
    logic [NIB_W-1:0]  rb_w;
    logic [WORD_W-1:0] valc_w;

    stage_t st_d;
    stage_t st_q;

    assign op_nib = window[BYTE_W-1 -: NIB_W];
    assign fn_nib = window[NIB_W-1:0];

    fd_class u_class (
        .opcode    (op_nib),
        .has_regs  (has_regs),
        .has_word  (has_word),
        .known     (known),
        .len_bytes (len_bytes)
    );

    fd_extract u_extract (
        .tail     (window[WIN_W-1:BYTE_W]),
        .has_regs (has_regs),
        .has_word (has_word),
        .ra       (ra_w),
        .rb       (rb_w),
        .valc     (valc_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.dec.icode       = op_nib;
            st_d.dec.ifun        = fn_nib;
            st_d.dec.ra          = ra_w;
            st_d.dec.rb          = rb_w;
            st_d.dec.valc        = valc_w;
            st_d.dec.valp        = pc + ADDR_W'(len_bytes);
            st_d.dec.need_regids = has_regs;
            st_d.dec.need_valc   = has_word;
            st_d.dec.instr_valid = known;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign icode       = st_q.dec.icode;
    assign ifun        = st_q.dec.ifun;
    assign ra          = st_q.dec.ra;
    assign rb          = st_q.dec.rb;
    assign valc        = st_q.dec.valc;
    assign valp        = st_q.dec.valp;
    assign need_regids = st_q.dec.need_regids;
    assign need_valc   = st_q.dec.need_valc;
    assign instr_valid = st_q.dec.instr_valid;

    // R6
    legal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((valp - $past(pc)) inside {32'd1, 32'd2, 32'd5, 32'd6}));

    // R7
    absent_regs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !need_regids) |-> (ra == '0 && rb == '0));

    // R7
    absent_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !need_valc) |-> (valc == '0));

    // R8
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !instr_valid) |->
            (!need_regids && !need_valc && valp == $past(pc) + 32'd1));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) && $past(rst_n)) |-> ($stable(valp) && $stable(icode) && !out_valid));

    // R3
    opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (icode == $past(window[7:4]) && ifun == $past(window[3:0])));

endmodule

// File: tb/fd_decode_test.sv
`timescale 1ns/1ps
module fd_decode_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] pc = '0;
    logic [47:0] window = '0;
    logic        out_valid;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, valp;
    logic        need_regids, need_valc, instr_valid;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    fd_decode uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .window(window),
        .out_valid(out_valid), .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
        .valc(valc), .valp(valp), .need_regids(need_regids), .need_valc(need_valc),
        .instr_valid(instr_valid)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [47:0] win;
        logic [3:0]  ic;
        logic [3:0]  fn;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [31:0] vc;
        logic [31:0] vp;
        logic        nr;
        logic        nc;
        logic        iv;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{32'h100, 48'h0000_000F_8330, 4'h3, 4'h0, 4'h8, 4'h3, 32'h0000000F, 32'h106, 1'b1, 1'b1, 1'b1},
        '{32'h106, 48'hAAAA_AAAA_3120, 4'h2, 4'h0, 4'h3, 4'h1, 32'h0,        32'h108, 1'b1, 1'b0, 1'b1},
        '{32'h108, 48'hFFFF_FFFD_1340, 4'h4, 4'h0, 4'h1, 4'h3, 32'hFFFFFFFD, 32'h10E, 1'b1, 1'b1, 1'b1},
        '{32'h10E, 48'h5555_5555_3160, 4'h6, 4'h0, 4'h3, 4'h1, 32'h0,        32'h110, 1'b1, 1'b0, 1'b1},
        '{32'h110, 48'hEE00_0001_0870, 4'h7, 4'h0, 4'h0, 4'h0, 32'h00000108, 32'h115, 1'b0, 1'b1, 1'b1},
        '{32'h202, 48'h7700_0002_0880, 4'h8, 4'h0, 4'h0, 4'h0, 32'h00000208, 32'h207, 1'b0, 1'b1, 1'b1},
        '{32'h207, 48'h0000_0A83_3010, 4'h1, 4'h0, 4'h0, 4'h0, 32'h0,        32'h208, 1'b0, 1'b0, 1'b1},
        '{32'h20E, 48'h1234_5678_9A90, 4'h9, 4'h0, 4'h0, 4'h0, 32'h0,        32'h20F, 1'b0, 1'b0, 1'b1},
        '{32'h200, 48'hFFFF_FFFF_68A0, 4'hA, 4'h0, 4'h6, 4'h8, 32'h0,        32'h202, 1'b1, 1'b0, 1'b1},
        '{32'h01C, 48'h0000_0000_08B0, 4'hB, 4'h0, 4'h0, 4'h8, 32'h0,        32'h01E, 1'b1, 1'b0, 1'b1},
        '{32'h300, 48'h0000_0007_5450, 4'h5, 4'h0, 4'h5, 4'h4, 32'h00000007, 32'h306, 1'b1, 1'b1, 1'b1},
        '{32'h400, 48'h0000_0000_1361, 4'h6, 4'h1, 4'h1, 4'h3, 32'h0,        32'h402, 1'b1, 1'b0, 1'b1},
        '{32'h402, 48'h1000_0004_0073, 4'h7, 4'h3, 4'h0, 4'h0, 32'h00000400, 32'h407, 1'b0, 1'b1, 1'b1},
        '{32'h500, 48'h9A78_5634_12C0, 4'hC, 4'h0, 4'h0, 4'h0, 32'h0,        32'h501, 1'b0, 1'b0, 1'b0},
        '{32'hFFFFFFFF, 48'h0000_0000_00F5, 4'hF, 4'h5, 4'h0, 4'h0, 32'h0,   32'h0,   1'b0, 1'b0, 1'b0},
        '{32'hFFFFFFFC, 48'h1234_5678_8030, 4'h3, 4'h0, 4'h8, 4'h0, 32'h12345678, 32'h2, 1'b1, 1'b1, 1'b1},
        '{32'h010, 48'hFFFF_FFFF_FF00, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0,        32'h011, 1'b0, 1'b0, 1'b1},
        '{32'hFFFFFFFE, 48'h0012_3456_7880, 4'h8, 4'h0, 4'h0, 4'h0, 32'h12345678, 32'h3, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_vec(input int idx);
        vec_t v;
        v = TBL[idx];
        chk("R2", $sformatf("v%0d out_valid", idx), 32'(out_valid), 32'd1);
        chk("R3", $sformatf("v%0d icode", idx), 32'(icode), 32'(v.ic));
        chk("R3", $sformatf("v%0d ifun", idx), 32'(ifun), 32'(v.fn));
        chk("R4", $sformatf("v%0d need_regids", idx), 32'(need_regids), 32'(v.nr));
        chk("R4", $sformatf("v%0d ra", idx), 32'(ra), 32'(v.ra));
        chk("R4", $sformatf("v%0d rb", idx), 32'(rb), 32'(v.rb));
        chk("R5", $sformatf("v%0d need_valc", idx), 32'(need_valc), 32'(v.nc));
        chk("R5", $sformatf("v%0d valc", idx), valc, v.vc);
        chk("R6", $sformatf("v%0d valp", idx), valp, v.vp);
        chk("R8", $sformatf("v%0d instr_valid", idx), 32'(instr_valid), 32'(v.iv));
    endtask

    initial begin : watchdog
        #(5.0 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R1", "reset valp", valp, 32'd0);
        chk("R1", "reset icode", 32'(icode), 32'd0);
        chk("R1", "reset valc", valc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "first edge out_valid", 32'(out_valid), 32'd0);
        chk("R1", "first edge instr_valid", 32'(instr_valid), 32'd0);

        // table walk: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            pc       = TBL[i].pc;
            window   = TBL[i].win;
            @(negedge clk);
            chk_vec(i);
        end

        // R2: idle cycle holds fields, out_valid drops
        in_valid = 1'b0;
        pc       = 32'h700;
        window   = 48'h0000_0000_1361;
        @(negedge clk);
        chk("R2", "idle out_valid", 32'(out_valid), 32'd0);
        chk("R2", "idle holds valp", valp, 32'h3);
        chk("R2", "idle holds icode", 32'(icode), 32'h8);
        chk("R2", "idle holds valc", valc, 32'h12345678);

        // R2: next accepted input updates after one edge
        in_valid = 1'b1;
        @(negedge clk);
        chk("R2", "resume out_valid", 32'(out_valid), 32'd1);
        chk("R7", "resume valc zero", valc, 32'd0);
        chk("R6", "resume valp", valp, 32'h702);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "midrun out_valid", 32'(out_valid), 32'd0);
        chk("R1", "midrun valp", valp, 32'd0);
        chk("R1", "midrun need_regids", 32'(need_regids), 32'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule